// File: doc/BRIEF.md
# Tamper Event Monitor with Timestamp Capture

This block watches two intrusion sources: an external tamper pin, where a high level signals an intrusion, and a battery-loss indication from the power-switching logic. Each source has its own sticky status flag. A flag stays set until software clears it by writing one to that bit. Any set flag drives an interrupt line to the CPU. On every detected event, the block copies the time and date word presented by the timekeeping counters into a stamp register. That register always holds the time of the newest event.

Detection is disarmed after reset. It arms itself the first time the calibration-done input is seen high, and it stays armed until the next reset. Software can switch detection and the interrupt on or off through a control register. Both switches are on after reset. Register access uses a simple write strobe, an address and write data. Read data is combinational from the address.

Top module: `tamper_monitor`

## Requirements
- R1: After reset, the status register (address 0) reads 0, the control register (address 1) reads 3 (bit 0 = detection enable, bit 1 = interrupt enable), the stamp register (address 2) reads 0, and `irq_o` is low.
- R2: When armed and enabled, a low-to-high transition of `tamper_pin_i` sets status bit 0 on the third rising clock edge after the pin goes high. A pin held high does not set the flag again after it has been cleared.
- R3: When armed and enabled, a low-to-high transition of `batt_lost_i` sets status bit 1 on the next rising clock edge.
- R4: Before `cal_done_i` has been sampled high, neither source sets a flag. After one sample of `cal_done_i` high, detection stays armed even when `cal_done_i` falls again.
- R5: While control bit 0 is 0, transitions on either source set no flag and leave the stamp register unchanged.
- R6: A write to address 0 clears each status bit whose write-data bit is 1 and leaves bits written with 0 unchanged.
- R7: `irq_o` is high exactly when at least one status bit is set and control bit 1 is 1.
- R8: Each detected event loads the stamp register with the `time_i` value present at the clock edge that sets the flag, replacing any earlier stamp even while a flag is still set.
- R9: If a source sets its flag in the same cycle that a write to address 0 clears that bit, the flag ends up set.
- R10: Control bits 1:0 are written at address 1 and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| tamper_pin_i | input | 1 | Asynchronous tamper pin, high = intrusion |
| batt_lost_i | input | 1 | Backup battery missing indication |
| cal_done_i | input | 1 | Calibration complete, arms detection |
| time_i | input | TS_W | Current time and date word from the counters |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Tamper interrupt |

## Verification
A software clear of the status register can land in the same cycle as a new event that sets the bit being cleared. The bench provokes this with the battery source, whose timing is exact. It raises `batt_lost_i` on the same cycle as a write of 3 to address 0 while both flags are already set. The outcome is judged at the ports: the status must read 2, since the pin flag is cleared and the battery flag is kept, and the stamp must hold the new time word. A separate case clears the pin flag while the pin stays high, to show that a held level causes no second event.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
  localparam int ADDR_W  = 2;
  localparam int NUM_SRC = 2;
  localparam int SRC_PIN = 0;
  localparam int SRC_BAT = 1;
  localparam int CTL_DET = 0;
  localparam int CTL_IRQ = 1;

  typedef enum logic [ADDR_W-1:0] {
    ADR_STATUS = 2'd0,
    ADR_CTRL   = 2'd1,
    ADR_STAMP  = 2'd2,
    ADR_NONE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/tamper_rst_sync.sv
module tamper_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/tamper_sync.sv
module tamper_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] stage_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_n_i) begin
          if (!rst_n_i) stage_q[g] <= 1'b0;
          else          stage_q[g] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_n_i) begin
          if (!rst_n_i) stage_q[g] <= 1'b0;
          else          stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/tamper_flags.sv
module tamper_flags
  import tamper_pkg::*;
#(
  parameter int TS_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic [TS_W-1:0]    time_i,
  output logic [NUM_SRC-1:0] flag_o,
  output logic [TS_W-1:0]    stamp_o
);
  logic [NUM_SRC-1:0] flag_q, flag_d;
  logic [TS_W-1:0]    stamp_q;
  logic               stamp_en;

  // a new event outranks a software clear of the same bit
  always_comb begin
    flag_d   = (flag_q & ~clr_i) | evt_i;
    stamp_en = |evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) flag_q <= '0;
    else          flag_q <= flag_d;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)      stamp_q <= '0;
    else if (stamp_en) stamp_q <= time_i;
  end

  assign flag_o  = flag_q;
  assign stamp_o = stamp_q;
endmodule

// File: rtl/tamper_regs.sv
module tamper_regs
  import tamper_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TS_W   = 32
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_SRC-1:0] flag_i,
  input  logic [TS_W-1:0]    stamp_i,
  output logic               det_en_o,
  output logic               irq_en_o,
  output logic [NUM_SRC-1:0] clr_o,
  output logic [DATA_W-1:0]  rdata_o
);
  logic [1:0] ctrl_q, ctrl_d;
  logic       ctrl_we;
  reg_addr_e  sel;
  logic       unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_comb begin
    sel     = reg_addr_e'(addr_i);
    ctrl_we = we_i && (sel == ADR_CTRL);
    ctrl_d  = ctrl_we ? wdata_i[1:0] : ctrl_q;
    clr_o   = (we_i && (sel == ADR_STATUS)) ? wdata_i[NUM_SRC-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) ctrl_q <= 2'b11;
    else          ctrl_q <= ctrl_d;
  end

  always_comb begin
    rdata_o = '0;
    case (sel)
      ADR_STATUS: rdata_o[NUM_SRC-1:0] = flag_i;
      ADR_CTRL:   rdata_o[1:0]         = ctrl_q;
      ADR_STAMP:  rdata_o[TS_W-1:0]    = stamp_i;
      default:    rdata_o              = '0;
    endcase
  end

  assign det_en_o = ctrl_q[CTL_DET];
  assign irq_en_o = ctrl_q[CTL_IRQ];
endmodule

// File: rtl/tamper_monitor.sv
module tamper_monitor
  import tamper_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int TS_W      = 32,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              tamper_pin_i,
  input  logic              batt_lost_i,
  input  logic              cal_done_i,
  input  logic [TS_W-1:0]   time_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic               rst_q_n;
  logic               pin_sync, pin_prev_q, batt_prev_q;
  logic               armed_q, armed_d;
  logic               det_en, irq_en, detect_on;
  logic [NUM_SRC-1:0] evt, clr, flag_q;
  logic [TS_W-1:0]    stamp_q;

  tamper_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .rst_n_o(rst_q_n)
  );

  tamper_sync #(.STAGES(SYNC_STGS)) i_pin_sync (
    .clk_i(clk_i), .rst_n_i(rst_q_n), .async_i(tamper_pin_i), .sync_o(pin_sync)
  );

  always_comb begin
    armed_d        = armed_q | cal_done_i;
    detect_on      = armed_q & det_en;
    evt[SRC_PIN]   = detect_on & pin_sync & ~pin_prev_q;
    evt[SRC_BAT]   = detect_on & batt_lost_i & ~batt_prev_q;
  end

  always_ff @(posedge clk_i or negedge rst_q_n) begin
    if (!rst_q_n) begin
      armed_q     <= 1'b0;
      pin_prev_q  <= 1'b0;
      batt_prev_q <= 1'b0;
    end else begin
      armed_q     <= armed_d;
      pin_prev_q  <= pin_sync;
      batt_prev_q <= batt_lost_i;
    end
  end

  tamper_flags #(.TS_W(TS_W)) i_flags (
    .clk_i(clk_i), .rst_n_i(rst_q_n), .evt_i(evt), .clr_i(clr),
    .time_i(time_i), .flag_o(flag_q), .stamp_o(stamp_q)
  );

  tamper_regs #(.DATA_W(DATA_W), .TS_W(TS_W)) i_regs (
    .clk_i(clk_i), .rst_n_i(rst_q_n), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .flag_i(flag_q), .stamp_i(stamp_q),
    .det_en_o(det_en), .irq_en_o(irq_en), .clr_o(clr), .rdata_o(reg_rdata_o)
  );

  assign irq_o = irq_en & (|flag_q);
endmodule

// File: rtl/tamper_monitor_chk.sv
module tamper_monitor_chk #(
  parameter int TS_W = 32
) (
  input logic            clk_i,
  input logic            rst_q_n,
  input logic            armed_q,
  input logic [1:0]      evt,
  input logic [1:0]      clr,
  input logic [1:0]      flag_q,
  input logic [TS_W-1:0] stamp_q,
  input logic [TS_W-1:0] time_i,
  input logic            irq_o
);
  // R4
  unarmed_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    !armed_q |-> (flag_q == 2'b00));

  // R9
  pin_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    evt[0] |=> flag_q[0]);

  // R3
  batt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    evt[1] |=> flag_q[1]);

  // R8
  stamp_load_chk: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    (evt != 2'b00) |=> (stamp_q == $past(time_i)));

  // R6
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    (evt == 2'b00 && clr == 2'b00) |=> $stable(flag_q));

  // R7
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    irq_o |-> (flag_q != 2'b00));
endmodule

bind tamper_monitor tamper_monitor_chk #(.TS_W(TS_W)) i_chk (
  .clk_i(clk_i), .rst_q_n(rst_q_n), .armed_q(armed_q), .evt(evt), .clr(clr),
  .flag_q(flag_q), .stamp_q(stamp_q), .time_i(time_i), .irq_o(irq_o)
);

// File: tb/test_tamper_monitor.sv
module test_tamper_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int TW = 32;

  logic          clk, rst_n, pin, batt, cal, we, irq;
  logic [TW-1:0] tval;
  logic [1:0]    addr;
  logic [DW-1:0] wdata, rdata;
  int            checks = 0;
  int            errors = 0;
  bit            done = 0;

  tamper_monitor #(.DATA_W(DW), .TS_W(TW)) i_tamper_monitor (
    .clk_i(clk), .rst_n_i(rst_n), .tamper_pin_i(pin), .batt_lost_i(batt),
    .cal_done_i(cal), .time_i(tval), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, v); check("R1 status", v, 0);
    rd(2'd1, v); check("R1 control", v, 3);
    rd(2'd2, v); check("R1 stamp", v, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_unarmed();
    logic [31:0] v;
    @(negedge clk); pin = 1'b1; batt = 1'b1; tval = 32'h0AA;
    idle(5);
    pin = 1'b0; batt = 1'b0;
    idle(4);
    rd(2'd0, v); check("R4 no flag before arming", v, 0);
    rd(2'd2, v); check("R4 stamp untouched before arming", v, 0);
    check("R4 irq", irq, 0);
    @(negedge clk); cal = 1'b1;
    @(negedge clk); cal = 1'b0;
    idle(2);
  endtask

  task automatic t_pin();
    logic [31:0] v;
    @(negedge clk); tval = 32'h100; pin = 1'b1;
    idle(2);
    rd(2'd0, v); check("R2 not yet set after two edges", v, 0);
    idle(1);
    rd(2'd0, v); check("R2 pin flag on third edge (R4 arm sticky)", v, 1);
    rd(2'd2, v); check("R8 stamp from pin event", v, 32'h100);
    check("R7 irq with pin flag", irq, 1);
    tval = 32'h1FF;
    wr(2'd0, 32'h1);
    idle(6);
    rd(2'd0, v); check("R2 held pin does not retrigger", v, 0);
    check("R7 irq low with no flags", irq, 0);
    @(negedge clk); pin = 1'b0;
    idle(3);
  endtask

  task automatic t_batt();
    logic [31:0] v;
    @(negedge clk); tval = 32'h200; batt = 1'b1;
    @(negedge clk);
    rd(2'd0, v); check("R3 battery flag next edge", v, 2);
    rd(2'd2, v); check("R8 stamp from battery event", v, 32'h200);
    wr(2'd0, 32'h1);
    rd(2'd0, v); check("R6 zero bit leaves flag", v, 2);
  endtask

  task automatic t_overwrite();
    logic [31:0] v;
    @(negedge clk); tval = 32'h300; pin = 1'b1;
    idle(3);
    rd(2'd0, v); check("R8 both flags set", v, 3);
    rd(2'd2, v); check("R8 stamp replaced by newer event", v, 32'h300);
    @(negedge clk); pin = 1'b0;
    idle(3);
  endtask

  task automatic t_irq_mask();
    logic [31:0] v;
    wr(2'd1, 32'h1);
    rd(2'd1, v); check("R10 control readback", v, 1);
    check("R7 irq masked", irq, 0);
    wr(2'd1, 32'h3);
    rd(2'd1, v); check("R10 control readback restored", v, 3);
    check("R7 irq unmasked", irq, 1);
  endtask

  task automatic t_coincide();
    logic [31:0] v;
    @(negedge clk); batt = 1'b0;
    @(negedge clk);
    tval = 32'h400; batt = 1'b1;
    we = 1'b1; addr = 2'd0; wdata = 32'h3;
    @(negedge clk);
    we = 1'b0; wdata = '0;
    rd(2'd0, v); check("R9 set beats clear, other bit cleared", v, 2);
    rd(2'd2, v); check("R9 stamp from coincident event", v, 32'h400);
  endtask

  task automatic t_disable();
    logic [31:0] v;
    wr(2'd0, 32'h3);
    @(negedge clk); batt = 1'b0;
    wr(2'd1, 32'h2);
    @(negedge clk); tval = 32'h500; pin = 1'b1; batt = 1'b1;
    idle(5);
    pin = 1'b0; batt = 1'b0;
    idle(4);
    rd(2'd0, v); check("R5 no flag while disabled", v, 0);
    rd(2'd2, v); check("R5 stamp unchanged while disabled", v, 32'h400);
    check("R5 irq", irq, 0);
    wr(2'd1, 32'h3);
  endtask

  initial begin
    rst_n = 1'b0; pin = 1'b0; batt = 1'b0; cal = 1'b0; we = 1'b0;
    addr = '0; wdata = '0; tval = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_unarmed();
    t_pin();
    t_batt();
    t_overwrite();
    t_irq_mask();
    t_coincide();
    t_disable();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule